// File: doc/BRIEF.md
# Programmable 16-bit Counter/Timer

This block divides a count-enable tick by a 16-bit divisor that software writes one byte at a time into an upper and a lower register. In timer mode it drives a continuous, symmetric square wave whose high and low phases each last exactly divisor ticks, so the output frequency is the tick rate over twice the divisor. In counter mode the same divisor sets a single delay: the output stays high for divisor ticks after a start and then drops low and stays there.

Start and stop are dataless command strobes. A start always copies the divisor bytes into the working counter and restarts the output from the high level. A ready flag is raised on every high-to-low edge of the output and is meant to drive an interrupt status bit. A stop clears that flag. In counter mode a stop also halts counting. In timer mode the wave keeps running and keeps raising the flag after a stop.

Top module: `ctr_timer16`

## Requirements
- R1: After reset the output `wave_o` is 1, `ready_o` is 0 and the counter is idle, so ticks arriving before the first start leave `wave_o` at 1.
- R2: A write with `wr_sel_i` = 1 loads the upper divisor byte and a write with `wr_sel_i` = 0 loads the lower byte. A start copies both bytes into the counter.
- R3: With `mode_i` = 1 (timer), a start drives `wave_o` to 1. The output then inverts after every divisor ticks, forever.
- R4: `ready_o` becomes 1 on the same clock edge where `wave_o` goes from 1 to 0, and it rises at no other time.
- R5: A cycle with `stop_i` high clears `ready_o` on the next edge, unless `wave_o` falls on that same edge, in which case `ready_o` is 1.
- R6: In timer mode a stop does not halt the wave. `wave_o` keeps toggling and its falling edges keep setting `ready_o`.
- R7: With `mode_i` = 0 (counter), a start drives `wave_o` to 1. After divisor ticks `wave_o` goes to 0 and then stays at 0 until the next start.
- R8: In counter mode a stop halts counting, so later ticks leave `wave_o` unchanged until the next start.
- R9: A divisor of 0 counts as 65536 ticks.
- R10: A start while the counter is running reloads the divisor and begins a fresh high phase.
- R11: Clock cycles with `tick_i` low do not advance the count.
- R12: In timer mode each new phase reloads the divisor registers, so a divisor written during a phase takes effect in the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Divisor byte write strobe |
| wr_sel_i | input | 1 | Byte select: 1 upper, 0 lower |
| wr_data_i | input | 8 | Divisor byte data |
| start_i | input | 1 | Start command strobe (dataless) |
| stop_i | input | 1 | Stop command strobe (dataless) |
| mode_i | input | 1 | 1 timer (square wave), 0 counter (one delay) |
| tick_i | input | 1 | Count enable from the prescaled clock source |
| wave_o | output | 1 | Counter/timer output |
| ready_o | output | 1 | Ready flag, set on each falling edge of `wave_o` |

## Verification
The assertions check several rules on every cycle. The ready flag rises only with a falling output edge, and every falling edge leaves it set. A stop leaves it clear unless a fall coincides with that stop. The output holds still on cycles that have neither a tick nor a start, and it rises only after a start or while in timer mode. The exact phase lengths can only be shown by the bench's directed scenarios: divisor-tick half periods, the 65536 case for a zero divisor, the one-time delay, the reload of a divisor written mid-phase, and a restart in the middle of a run.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_TIMER = 1'b1
  } ct_mode_e;
endpackage

// File: rtl/ctr_timer_regs.sv
module ctr_timer_regs
  import ctr_timer_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned NUM_BYTES = DIV_W / BYTE_W,
  localparam int unsigned SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  div_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (wr_en_i && (wr_sel_i == SEL_W'(b))) byte_q <= wr_data_i;
    end
    assign div_o[b*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/ctr_timer_core.sv
module ctr_timer_core
  import ctr_timer_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  ct_mode_e         mode_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             wave_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             wave_q, wave_d;

  // divisor 0 wraps through all ones and so lasts 2**DIV_W ticks
  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    wave_d = wave_q;
    if (start_i) begin
      cnt_d  = div_i;
      run_d  = 1'b1;
      wave_d = 1'b1;
    end else if (stop_i && mode_i == MODE_COUNT) begin
      run_d = 1'b0;
    end else if (run_q && tick_i) begin
      if (cnt_q == DIV_W'(1)) begin
        cnt_d = div_i;
        if (mode_i == MODE_TIMER) begin
          wave_d = ~wave_q;
        end else begin
          wave_d = 1'b0;
          run_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;
  assign fall_o = wave_q & ~wave_d;
endmodule

// File: rtl/ctr_timer_flag.sv
module ctr_timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // a set on the same edge as a clear wins, so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/ctr_timer16.sv
module ctr_timer16
  import ctr_timer_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned NUM_BYTES = DIV_W / BYTE_W,
  localparam int unsigned SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic              tick_i,
  output logic              wave_o,
  output logic              ready_o
);
  logic [DIV_W-1:0] div;
  logic             fall;

  ctr_timer_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .div_o(div)
  );

  ctr_timer_core #(.DIV_W(DIV_W)) u_core (
    .clk_i, .rst_ni, .start_i, .stop_i,
    .mode_i(ct_mode_e'(mode_i)),
    .tick_i, .div_i(div), .wave_o, .fall_o(fall)
  );

  ctr_timer_flag u_flag (
    .clk_i, .rst_ni, .set_i(fall), .clr_i(stop_i), .flag_o(ready_o)
  );
endmodule

// File: rtl/ctr_timer16_chk.sv
module ctr_timer16_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic mode_i,
  input logic tick_i,
  input logic wave_o,
  input logic ready_o
);
  a_r4_fall_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wave_o) |-> ready_o);

  a_r4_ready_rise_needs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $fell(wave_o));

  a_r5_stop_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!ready_o || $fell(wave_o)));

  a_r11_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> $stable(wave_o));

  a_r7_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wave_o) |-> ($past(start_i) || $past(mode_i)));
endmodule

bind ctr_timer16 ctr_timer16_chk u_chk (.*);

// File: tb/ctr_timer16_test.sv
`timescale 1ns/1ps
module ctr_timer16_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       mode_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       wave_o;
  logic       ready_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  ctr_timer16 uut (.*);

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic set_div(logic [15:0] d);
    wr(1'b0, d[7:0]);
    wr(1'b1, d[15:8]);
  endtask

  task automatic cmd_start();
    @(negedge clk_i); start_i = 1'b1; wr_data_i = 8'hA5;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic cmd_stop();
    @(negedge clk_i); stop_i = 1'b1; wr_data_i = 8'h5A;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk_i); tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 wave after reset", wave_o, 1'b1);
    check("R1 ready after reset", ready_o, 1'b0);
    ticks(5);
    check("R1 idle before start", wave_o, 1'b1);
  endtask

  task automatic t_timer();
    mode_i = 1'b1;
    set_div(16'd3);
    cmd_start();
    check("R3 start high", wave_o, 1'b1);
    ticks(2);
    check("R3 high before divisor", wave_o, 1'b1);
    ticks(1);
    check("R3 low after divisor", wave_o, 1'b0);
    check("R4 ready on fall", ready_o, 1'b1);
    ticks(3);
    check("R3 high again", wave_o, 1'b1);
    cmd_stop();
    check("R5 stop clears ready", ready_o, 1'b0);
    ticks(3);
    check("R6 toggles after stop", wave_o, 1'b0);
    check("R6 ready after stop", ready_o, 1'b1);
    repeat (5) @(negedge clk_i);
    check("R11 no tick no change", wave_o, 1'b0);
    ticks(3);
    check("R6 still running", wave_o, 1'b1);
  endtask

  task automatic t_reload();
    // wave just rose with 3 loaded; new divisor applies to the next phase
    wr(1'b0, 8'd5);
    ticks(3);
    check("R12 current phase keeps old divisor", wave_o, 1'b0);
    ticks(4);
    check("R12 new phase not yet done", wave_o, 1'b0);
    ticks(1);
    check("R12 new phase length", wave_o, 1'b1);
  endtask

  task automatic t_coincident();
    set_div(16'd2);
    cmd_start();
    cmd_stop();
    check("R5 cleared", ready_o, 1'b0);
    ticks(1);
    @(negedge clk_i); tick_i = 1'b1; stop_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0; stop_i = 1'b0;
    check("R5 fall wins over stop", ready_o, 1'b1);
    check("R5 wave fell", wave_o, 1'b0);
  endtask

  task automatic t_restart();
    set_div(16'd4);
    cmd_start();
    ticks(3);
    cmd_start();
    ticks(3);
    check("R10 restart high", wave_o, 1'b1);
    ticks(1);
    check("R10 restart full phase", wave_o, 1'b0);
  endtask

  task automatic t_counter();
    mode_i = 1'b0;
    set_div(16'h0102);
    cmd_stop();
    cmd_start();
    check("R7 start high", wave_o, 1'b1);
    ticks(257);
    check("R2 upper byte counted", wave_o, 1'b1);
    ticks(1);
    check("R2 delay 258", wave_o, 1'b0);
    check("R7 ready at end", ready_o, 1'b1);
    ticks(600);
    check("R7 stays low", wave_o, 1'b0);
  endtask

  task automatic t_counter_stop();
    set_div(16'd10);
    cmd_start();
    ticks(5);
    cmd_stop();
    check("R8 stop clears ready", ready_o, 1'b0);
    ticks(500);
    check("R8 halted high", wave_o, 1'b1);
    check("R8 no ready", ready_o, 1'b0);
  endtask

  task automatic t_zero();
    set_div(16'd0);
    cmd_start();
    ticks(65535);
    check("R9 not done at 65535", wave_o, 1'b1);
    ticks(1);
    check("R9 done at 65536", wave_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_timer();
    t_reload();
    t_coincident();
    t_restart();
    t_counter();
    t_counter_stop();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule